// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the timing skeleton of a raster display. It runs one pixel per clock. A column counter sweeps each line, and a line counter steps once per line. From the two counter positions it derives horizontal and vertical sync, a flag for the visible picture area and a vertical blanking flag. A horizontal timing set and a vertical timing set are given as parameters. Each set holds the visible length, the first sync position, the first position after sync and the total length.

Downstream pixel pipelines often need to prepare work before a boundary arrives. For that the block also gives look-ahead strobes. They mark the last clock of a line, the last clock of a frame and the clock before it, and the last one or two clocks before a line that holds visible pixels. Every output is a register. Each register is loaded from the decode of the next counter position, so flags and counters always describe the same pixel.

Top module: `raster_timing_gen`

## Requirements
- R1: `col` counts up by one each clock from 0 to H_TOTAL-1, then returns to 0.
- R2: `row` holds its value except on a clock where `col` equals H_TOTAL-1. There it advances by one, and after V_TOTAL-1 it returns to 0.
- R3: `hsync` is 1 exactly when H_SYNC_BEGIN <= `col` < H_SYNC_END. `vsync` is 1 exactly when V_SYNC_BEGIN <= `row` < V_SYNC_END.
- R4: `active` is 1 exactly when `col` < H_ACTIVE and `row` < V_ACTIVE.
- R5: `line_end` is 1 exactly when `col` equals H_TOTAL-1.
- R6: `frame_end` is 1 exactly when `col` is H_TOTAL-1 and `row` is V_TOTAL-1. `frame_end_m2` is 1 exactly when `col` is H_TOTAL-2 and `row` is V_TOTAL-1, so it leads `frame_end` by one clock.
- R7: `vblank` is 1 when `row` >= V_ACTIVE. It is also 1 when `row` equals V_ACTIVE-1 and `col` >= H_ACTIVE. It is 0 otherwise.
- R8: `vis_line_next` is 1 exactly when `col` is H_TOTAL-1 and either `row` is V_TOTAL-1 or `row` < V_ACTIVE-1. `vis_line_next_m2` applies the same row condition at `col` equal to H_TOTAL-2.
- R9: While `rst` is high at a rising clock edge, the next state is `col` = 0 and `row` = 0, with every flag decoded for that position. Counting resumes from there on the first edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| col | output | XW | Current pixel column |
| row | output | YW | Current line |
| hsync | output | 1 | Horizontal sync window |
| vsync | output | 1 | Vertical sync window |
| active | output | 1 | Visible picture area |
| vblank | output | 1 | Vertical blanking, starts after the last visible pixel |
| line_end | output | 1 | Last column of a line |
| frame_end | output | 1 | Last clock of a frame |
| frame_end_m2 | output | 1 | Clock before the last clock of a frame |
| vis_line_next | output | 1 | Last clock before a line with visible pixels |
| vis_line_next_m2 | output | 1 | Second-to-last clock before a line with visible pixels |

XW is the bit width needed for H_TOTAL-1, and YW is the bit width needed for V_TOTAL-1.

## Verification
The bench builds the block with an 11-column by 7-line raster:
- H_ACTIVE = 6, horizontal sync over columns 7 to 8.
- V_ACTIVE = 4, vertical sync on line 5.

With a frame of only 77 clocks, three whole frames take a few hundred clocks. This covers every pixel position several times, including each counter wrap and frame wrap. It also covers the partial-line start of blanking on line 3 and the last-line case of the visible-line strobes. Sync ends before the total, so each sync window has both a rising and a falling edge. A reset applied in the middle of a frame checks the return to the origin.

// File: rtl/raster_pkg.sv
package raster_pkg;

   typedef struct packed {
      logic hsync;
      logic vsync;
      logic active;
      logic vblank;
      logic line_end;
      logic frame_end;
      logic frame_end_m2;
      logic vis_next;
      logic vis_next_m2;
   } raster_flags_t;

   function automatic int width_for(input int count);
      int w;
      w = 1;
      while ((1 << w) < count) w = w + 1;
      return w;
   endfunction

endpackage

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
   parameter int TOTAL = 8,
   parameter int W     = 3
) (
   input  logic [W-1:0] cur,
   input  logic         step,
   input  logic         clear,
   output logic [W-1:0] nxt,
   output logic         at_last
);
   generate
      if (TOTAL < 2) begin : g_bad_total
         $error("raster_axis_counter: TOTAL must be at least 2");
      end
      if ((1 << W) < TOTAL) begin : g_bad_width
         $error("raster_axis_counter: W too small for TOTAL");
      end
   endgenerate

   always_comb begin
      at_last = (int'(cur) == TOTAL - 1);
      if (clear)
         nxt = '0;
      else if (!step)
         nxt = cur;
      else if (at_last)
         nxt = '0;
      else
         nxt = cur + 1'b1;
   end
endmodule

// File: rtl/raster_decode.sv
module raster_decode
   import raster_pkg::*;
#(
   parameter int H_ACTIVE      = 6,
   parameter int H_SYNC_BEGIN  = 7,
   parameter int H_SYNC_END    = 9,
   parameter int H_TOTAL       = 11,
   parameter int V_ACTIVE      = 4,
   parameter int V_SYNC_BEGIN  = 5,
   parameter int V_SYNC_END    = 6,
   parameter int V_TOTAL       = 7,
   parameter int XW            = 4,
   parameter int YW            = 3
) (
   input  logic [XW-1:0]  x,
   input  logic [YW-1:0]  y,
   output raster_flags_t  flags
);
   localparam int X_LAST  = H_TOTAL - 1;
   localparam int X_LAST2 = H_TOTAL - 2;
   localparam int Y_LAST  = V_TOTAL - 1;

   logic x_last, x_last2, y_last, vis_row_cond;

   always_comb begin
      x_last       = (int'(x) == X_LAST);
      x_last2      = (int'(x) == X_LAST2);
      y_last       = (int'(y) == Y_LAST);
      vis_row_cond = y_last || (int'(y) < V_ACTIVE - 1);

      flags.hsync        = (int'(x) >= H_SYNC_BEGIN) && (int'(x) < H_SYNC_END);
      flags.vsync        = (int'(y) >= V_SYNC_BEGIN) && (int'(y) < V_SYNC_END);
      flags.active       = (int'(x) < H_ACTIVE) && (int'(y) < V_ACTIVE);
      flags.vblank       = (int'(y) >= V_ACTIVE) ||
                           ((int'(y) == V_ACTIVE - 1) && (int'(x) >= H_ACTIVE));
      flags.line_end     = x_last;
      flags.frame_end    = x_last && y_last;
      flags.frame_end_m2 = x_last2 && y_last;
      flags.vis_next     = x_last && vis_row_cond;
      flags.vis_next_m2  = x_last2 && vis_row_cond;
   end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_pkg::*;
#(
   parameter int H_ACTIVE      = 6,
   parameter int H_SYNC_BEGIN  = 7,
   parameter int H_SYNC_END    = 9,
   parameter int H_TOTAL       = 11,
   parameter int V_ACTIVE      = 4,
   parameter int V_SYNC_BEGIN  = 5,
   parameter int V_SYNC_END    = 6,
   parameter int V_TOTAL       = 7,
   localparam int XW           = width_for(H_TOTAL),
   localparam int YW           = width_for(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [XW-1:0] col,
   output logic [YW-1:0] row,
   output logic          hsync,
   output logic          vsync,
   output logic          active,
   output logic          vblank,
   output logic          line_end,
   output logic          frame_end,
   output logic          frame_end_m2,
   output logic          vis_line_next,
   output logic          vis_line_next_m2
);
   generate
      if (H_TOTAL < 3) begin : g_bad_htotal
         $error("raster_timing_gen: H_TOTAL must be at least 3");
      end
      if (V_TOTAL < 2) begin : g_bad_vtotal
         $error("raster_timing_gen: V_TOTAL must be at least 2");
      end
      if (H_ACTIVE < 1 || H_ACTIVE > H_TOTAL) begin : g_bad_hact
         $error("raster_timing_gen: H_ACTIVE out of range");
      end
      if (V_ACTIVE < 1 || V_ACTIVE > V_TOTAL) begin : g_bad_vact
         $error("raster_timing_gen: V_ACTIVE out of range");
      end
      if (H_SYNC_BEGIN > H_SYNC_END || H_SYNC_END > H_TOTAL) begin : g_bad_hsync
         $error("raster_timing_gen: horizontal sync window out of range");
      end
      if (V_SYNC_BEGIN > V_SYNC_END || V_SYNC_END > V_TOTAL) begin : g_bad_vsync
         $error("raster_timing_gen: vertical sync window out of range");
      end
   endgenerate

   logic [XW-1:0] col_nxt;
   logic [YW-1:0] row_nxt;
   logic          col_wrap;
   logic          row_wrap_unused;
   raster_flags_t flags_nxt;
   raster_flags_t flags_q;

   raster_axis_counter #(.TOTAL(H_TOTAL), .W(XW)) u_col (
      .cur     (col),
      .step    (1'b1),
      .clear   (rst),
      .nxt     (col_nxt),
      .at_last (col_wrap)
   );

   raster_axis_counter #(.TOTAL(V_TOTAL), .W(YW)) u_row (
      .cur     (row),
      .step    (col_wrap),
      .clear   (rst),
      .nxt     (row_nxt),
      .at_last (row_wrap_unused)
   );

   raster_decode #(
      .H_ACTIVE     (H_ACTIVE),
      .H_SYNC_BEGIN (H_SYNC_BEGIN),
      .H_SYNC_END   (H_SYNC_END),
      .H_TOTAL      (H_TOTAL),
      .V_ACTIVE     (V_ACTIVE),
      .V_SYNC_BEGIN (V_SYNC_BEGIN),
      .V_SYNC_END   (V_SYNC_END),
      .V_TOTAL      (V_TOTAL),
      .XW           (XW),
      .YW           (YW)
   ) u_dec (
      .x     (col_nxt),
      .y     (row_nxt),
      .flags (flags_nxt)
   );

   always_ff @(posedge clk) begin
      col     <= col_nxt;
      row     <= row_nxt;
      flags_q <= flags_nxt;
   end

   assign hsync            = flags_q.hsync;
   assign vsync            = flags_q.vsync;
   assign active           = flags_q.active;
   assign vblank           = flags_q.vblank;
   assign line_end         = flags_q.line_end;
   assign frame_end        = flags_q.frame_end;
   assign frame_end_m2     = flags_q.frame_end_m2;
   assign vis_line_next    = flags_q.vis_next;
   assign vis_line_next_m2 = flags_q.vis_next_m2;
endmodule

// File: rtl/raster_timing_checker.sv
module raster_timing_checker #(
   parameter int H_TOTAL = 11,
   parameter int V_TOTAL = 7,
   parameter int XW      = 4,
   parameter int YW      = 3
) (
   input logic          clk,
   input logic          rst,
   input logic [XW-1:0] col,
   input logic [YW-1:0] row,
   input logic          active,
   input logic          vblank,
   input logic          line_end,
   input logic          frame_end,
   input logic          frame_end_m2,
   input logic          vis_line_next,
   input logic          vis_line_next_m2
);
   localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);

   AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
      (col == X_LAST) |=> (col == '0)); // R1
   AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
      (col != X_LAST) |=> (col == $past(col) + 1'b1)); // R1
   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
      (col != X_LAST) |=> $stable(row)); // R2
   AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
      (col == X_LAST && row == Y_LAST) |=> (row == '0)); // R2
   AST_LINE_STROBE: assert property (@(posedge clk) disable iff (rst)
      line_end |-> (col == X_LAST)); // R5
   AST_FRAME_AHEAD: assert property (@(posedge clk) disable iff (rst)
      frame_end_m2 |=> frame_end); // R6
   AST_VISIBLE_NOT_BLANK: assert property (@(posedge clk) disable iff (rst)
      active |-> !vblank); // R7
   AST_VIS_AHEAD: assert property (@(posedge clk) disable iff (rst)
      vis_line_next_m2 |=> vis_line_next); // R8
   AST_RESET_ORIGIN: assert property (@(posedge clk)
      $past(rst) |-> (col == '0 && row == '0)); // R9
endmodule

bind raster_timing_gen raster_timing_checker #(
   .H_TOTAL (H_TOTAL),
   .V_TOTAL (V_TOTAL),
   .XW      (XW),
   .YW      (YW)
) u_chk (
   .clk              (clk),
   .rst              (rst),
   .col              (col),
   .row              (row),
   .active           (active),
   .vblank           (vblank),
   .line_end         (line_end),
   .frame_end        (frame_end),
   .frame_end_m2     (frame_end_m2),
   .vis_line_next    (vis_line_next),
   .vis_line_next_m2 (vis_line_next_m2)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
   localparam int CLK_PERIOD = 10;
   localparam int HA = 6, HSB = 7, HSE = 9, HT = 11;
   localparam int VA = 4, VSB = 5, VSE = 6, VT = 7;
   localparam int XW = 4, YW = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [XW-1:0] col;
   logic [YW-1:0] row;
   logic hsync, vsync, active, vblank, line_end, frame_end, frame_end_m2;
   logic vis_line_next, vis_line_next_m2;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   raster_timing_gen #(
      .H_ACTIVE(HA), .H_SYNC_BEGIN(HSB), .H_SYNC_END(HSE), .H_TOTAL(HT),
      .V_ACTIVE(VA), .V_SYNC_BEGIN(VSB), .V_SYNC_END(VSE), .V_TOTAL(VT)
   ) dut (
      .clk(clk), .rst(rst), .col(col), .row(row),
      .hsync(hsync), .vsync(vsync), .active(active), .vblank(vblank),
      .line_end(line_end), .frame_end(frame_end), .frame_end_m2(frame_end_m2),
      .vis_line_next(vis_line_next), .vis_line_next_m2(vis_line_next_m2)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_pos(input int x, input int y);
      bit vis_cond;
      vis_cond = (y == VT-1) || (y < VA-1);
      chk("R1", "col", int'(col), x);
      chk("R2", "row", int'(row), y);
      chk("R3", "hsync", int'(hsync), int'(x >= HSB && x < HSE));
      chk("R3", "vsync", int'(vsync), int'(y >= VSB && y < VSE));
      chk("R4", "active", int'(active), int'(x < HA && y < VA));
      chk("R7", "vblank", int'(vblank), int'(y >= VA || (y == VA-1 && x >= HA)));
      chk("R5", "line_end", int'(line_end), int'(x == HT-1));
      chk("R6", "frame_end", int'(frame_end), int'(x == HT-1 && y == VT-1));
      chk("R6", "frame_end_m2", int'(frame_end_m2), int'(x == HT-2 && y == VT-1));
      chk("R8", "vis_line_next", int'(vis_line_next), int'(x == HT-1 && vis_cond));
      chk("R8", "vis_line_next_m2", int'(vis_line_next_m2), int'(x == HT-2 && vis_cond));
   endtask

   task automatic sweep(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         check_pos(c % HT, (c / HT) % VT);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: state held at the origin while reset is high
      check_pos(0, 0);
      rst = 1'b0;
      // three full frames plus a partial one
      sweep(3 * HT * VT + 5);
      // R9: reset in mid-frame
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_pos(0, 0);
      rst = 1'b0;
      sweep(HT * VT + HT + 3);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule